// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a single-word-per-line, write-back, write-allocate cache for a word-addressed client. Its main store is a direct-mapped array. Beside it sits a small fully associative buffer that keeps lines which conflicts pushed out of the array. Every request checks both stores in the same cycle. A block lives in exactly one of them, or in neither.

Each hit in the array completes in one cycle. When the requested block is in the side buffer, it trades places with whatever occupies its array slot, and the request completes one cycle later. When both stores miss, the array line is moved into the side buffer at its allocation pointer. If the entry being overwritten there is dirty, it is first written back over a request/response memory port. A read miss then fetches the word. A write miss installs the word directly, because the write covers the whole line.

Top module: `vcache_top`

## Requirements
- R1: After reset every line of both stores is invalid, `cpu_req_ready` is 1, and `cpu_resp_valid` and `mem_req_valid` are 0; the first access to any address misses.
- R2: A request that hits the direct-mapped array gives `cpu_resp_valid` one cycle after acceptance, with no memory traffic. A read returns the stored word. A write stores `cpu_req_wdata`, marks the line dirty and returns the written word.
- R3: The word address is split with its low 4 bits as the array index and the upper 8 bits as the tag. Addresses with different indices never displace one another.
- R4: A read that misses both stores issues one memory read for the requested address. Its data is installed and returned on the cycle after `mem_resp_valid`, which gives 3 cycles from acceptance with a 2-cycle memory.
- R5: A write that misses both stores allocates the line without a memory read. With no write-back due, it responds one cycle after acceptance.
- R6: A valid line displaced from the array is kept in the victim buffer, so a later access to it is served without memory traffic.
- R7: A victim-buffer hit responds two cycles after acceptance and swaps the requested line into its array slot, with the displaced array line taking the vacated buffer entry. The next access to the requested block is then an array hit.
- R8: Victim insertions use the buffer entries in rotating allocation order. The entry overwritten is the earliest allocated, and a clean overwritten entry is dropped with no memory write.
- R9: A dirty victim entry that is about to be overwritten is first written to memory with its full block address and data, before any read for the miss.
- R10: A block is present in at most one place: never in both stores, and in at most one victim entry. A read always returns the latest written value.
- R11: `cpu_req_ready` is 0 from acceptance of a swap or miss until its response cycle, and in particular whenever `mem_req_valid` is 1.
- R12: `mem_req_valid`, `mem_req_write`, `mem_req_addr` and `mem_req_wdata` stay unchanged from the cycle a memory request starts until the cycle `mem_resp_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Client request present |
| cpu_req_ready | output | 1 | Cache can accept a request this cycle |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 12 | Word address (tag 11:4, index 3:0) |
| cpu_req_wdata | input | 32 | Write data |
| cpu_resp_valid | output | 1 | One-cycle response strobe |
| cpu_resp_rdata | output | 32 | Read data, or the written word for a write |
| mem_req_valid | output | 1 | Memory request, held until answered |
| mem_req_write | output | 1 | 1 = write-back, 0 = line fetch |
| mem_req_addr | output | 12 | Memory word address |
| mem_req_wdata | output | 32 | Write-back data |
| mem_resp_valid | input | 1 | Memory completes the current request |
| mem_resp_rdata | input | 32 | Fetched word |

## Verification
The checker watches several properties on every clock. It holds the response timing after array hits, victim hits and read-fill completions. It holds the stability of a pending memory request and the low ready while memory is busy. It also holds the uniqueness of a block across the array and the victim entries. The allocation order of victim entries, dropping clean lines and writing back dirty ones, and the survival of written data across swaps and evictions cannot be seen in a single cycle. The bench shows these through a fixed conflict sequence on one index, counting memory traffic and latency per access.

// File: rtl/vcache_pkg.sv
package vcache_pkg;
    localparam int unsigned ADDR_W     = 12;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned IDX_W      = 4;
    localparam int unsigned VB_ENTRIES = 4;
    localparam int unsigned DM_LINES   = 1 << IDX_W;
    localparam int unsigned TAG_W      = ADDR_W - IDX_W;
    localparam int unsigned VB_PTR_W   = (VB_ENTRIES > 1) ? $clog2(VB_ENTRIES) : 1;

    typedef struct packed {
        logic              valid;
        logic              dirty;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } dm_line_t;

    typedef struct packed {
        logic              valid;
        logic              dirty;
        logic [ADDR_W-1:0] blk;
        logic [DATA_W-1:0] data;
    } vb_line_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SWAP  = 2'd1,
        ST_WB    = 2'd2,
        ST_FETCH = 2'd3
    } ctl_st_e;

    typedef struct packed {
        ctl_st_e                          st;
        dm_line_t [DM_LINES-1:0]          dm;
        vb_line_t [VB_ENTRIES-1:0]        vb;
        logic [VB_PTR_W-1:0]              vptr;
        logic                             pend_wr;
        logic [ADDR_W-1:0]                pend_addr;
        logic [DATA_W-1:0]                pend_wdata;
        logic [VB_PTR_W-1:0]              pend_vidx;
        logic                             resp_vld;
        logic [DATA_W-1:0]                resp_data;
    } ctl_regs_t;
endpackage

// File: rtl/vcache_dm_probe.sv
module vcache_dm_probe
    import vcache_pkg::*;
(
    input  dm_line_t [DM_LINES-1:0] lines,
    input  logic [ADDR_W-1:0]       addr,
    output logic                    hit,
    output dm_line_t                line
);
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;

    always_comb begin
        idx  = addr[IDX_W-1:0];
        tag  = addr[ADDR_W-1:IDX_W];
        line = lines[idx];
        hit  = line.valid && (line.tag == tag);
    end
endmodule

// File: rtl/vcache_vb_probe.sv
module vcache_vb_probe
    import vcache_pkg::*;
(
    input  logic [VB_ENTRIES-1:0]             valid,
    input  logic [VB_ENTRIES-1:0][ADDR_W-1:0] blk,
    input  logic [ADDR_W-1:0]                 addr,
    output logic [VB_ENTRIES-1:0]             hit_vec,
    output logic [VB_PTR_W-1:0]               hit_idx
);
    genvar g;
    generate
        for (g = 0; g < VB_ENTRIES; g++) begin : g_cmp
            assign hit_vec[g] = valid[g] && (blk[g] == addr);
        end
    endgenerate

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < VB_ENTRIES; i++) begin
            if (hit_vec[i]) hit_idx = VB_PTR_W'(i);
        end
    end
endmodule

// File: rtl/vcache_top.sv
module vcache_top
    import vcache_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_resp_valid,
    input  logic [DATA_W-1:0] mem_resp_rdata
);
    ctl_regs_t q, d;

    logic                             dm_hit;
    dm_line_t                         dm_sel;
    logic [VB_ENTRIES-1:0]            vb_valid;
    logic [VB_ENTRIES-1:0][ADDR_W-1:0] vb_blk;
    logic [VB_ENTRIES-1:0]            vb_hit_vec;
    logic [VB_PTR_W-1:0]              vb_hit_idx;
    logic                             vb_hit;

    genvar g;
    generate
        for (g = 0; g < VB_ENTRIES; g++) begin : g_vbv
            assign vb_valid[g] = q.vb[g].valid;
            assign vb_blk[g]   = q.vb[g].blk;
        end
    endgenerate

    vcache_dm_probe dm_probe_i (
        .lines (q.dm),
        .addr  (cpu_req_addr),
        .hit   (dm_hit),
        .line  (dm_sel)
    );

    vcache_vb_probe vb_probe_i (
        .valid   (vb_valid),
        .blk     (vb_blk),
        .addr    (cpu_req_addr),
        .hit_vec (vb_hit_vec),
        .hit_idx (vb_hit_idx)
    );

    assign vb_hit = |vb_hit_vec;

    function automatic logic [VB_PTR_W-1:0] ptr_next(input logic [VB_PTR_W-1:0] p);
        if (p == VB_PTR_W'(VB_ENTRIES - 1)) return '0;
        return p + VB_PTR_W'(1);
    endfunction

    always_comb begin : next_p
        logic              inst_en;
        logic [ADDR_W-1:0] inst_addr;
        logic              inst_wr;
        logic [DATA_W-1:0] inst_data;
        dm_line_t          disp;
        logic [IDX_W-1:0]  ii;
        logic [IDX_W-1:0]  pidx;
        dm_line_t          old_dm;
        vb_line_t          hit_ent;

        d         = q;
        d.resp_vld = 1'b0;
        inst_en   = 1'b0;
        inst_addr = q.pend_addr;
        inst_wr   = q.pend_wr;
        inst_data = q.pend_wdata;
        disp      = q.dm[q.pend_addr[IDX_W-1:0]];
        ii        = '0;
        pidx      = q.pend_addr[IDX_W-1:0];
        old_dm    = q.dm[pidx];
        hit_ent   = q.vb[q.pend_vidx];

        unique case (q.st)
            ST_IDLE: begin
                if (cpu_req_valid) begin
                    d.pend_wr    = cpu_req_write;
                    d.pend_addr  = cpu_req_addr;
                    d.pend_wdata = cpu_req_wdata;
                    if (dm_hit) begin
                        d.resp_vld = 1'b1;
                        if (cpu_req_write) begin
                            d.dm[cpu_req_addr[IDX_W-1:0]].data  = cpu_req_wdata;
                            d.dm[cpu_req_addr[IDX_W-1:0]].dirty = 1'b1;
                            d.resp_data = cpu_req_wdata;
                        end else begin
                            d.resp_data = dm_sel.data;
                        end
                    end else if (vb_hit) begin
                        d.pend_vidx = vb_hit_idx;
                        d.st        = ST_SWAP;
                    end else if (dm_sel.valid && q.vb[q.vptr].valid && q.vb[q.vptr].dirty) begin
                        d.st = ST_WB;
                    end else if (cpu_req_write) begin
                        inst_en   = 1'b1;
                        inst_addr = cpu_req_addr;
                        inst_wr   = 1'b1;
                        inst_data = cpu_req_wdata;
                        disp      = dm_sel;
                    end else begin
                        d.st = ST_FETCH;
                    end
                end
            end
            ST_SWAP: begin
                d.dm[pidx] = '{valid: 1'b1,
                               dirty: hit_ent.dirty | q.pend_wr,
                               tag:   q.pend_addr[ADDR_W-1:IDX_W],
                               data:  q.pend_wr ? q.pend_wdata : hit_ent.data};
                d.vb[q.pend_vidx] = '{valid: old_dm.valid,
                                      dirty: old_dm.dirty,
                                      blk:   {old_dm.tag, pidx},
                                      data:  old_dm.data};
                d.resp_vld  = 1'b1;
                d.resp_data = q.pend_wr ? q.pend_wdata : hit_ent.data;
                d.st        = ST_IDLE;
            end
            ST_WB: begin
                if (mem_resp_valid) begin
                    d.vb[q.vptr].valid = 1'b0;
                    if (q.pend_wr) inst_en = 1'b1;
                    else           d.st    = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (mem_resp_valid) begin
                    inst_en   = 1'b1;
                    inst_data = mem_resp_rdata;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (inst_en) begin
            ii = inst_addr[IDX_W-1:0];
            if (disp.valid) begin
                d.vb[q.vptr] = '{valid: 1'b1,
                                 dirty: disp.dirty,
                                 blk:   {disp.tag, ii},
                                 data:  disp.data};
                d.vptr = ptr_next(q.vptr);
            end
            d.dm[ii] = '{valid: 1'b1,
                         dirty: inst_wr,
                         tag:   inst_addr[ADDR_W-1:IDX_W],
                         data:  inst_data};
            d.resp_vld  = 1'b1;
            d.resp_data = inst_data;
            d.st        = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cpu_req_ready  = (q.st == ST_IDLE);
    assign cpu_resp_valid = q.resp_vld;
    assign cpu_resp_rdata = q.resp_data;
    assign mem_req_valid  = (q.st == ST_WB) || (q.st == ST_FETCH);
    assign mem_req_write  = (q.st == ST_WB);
    assign mem_req_addr   = (q.st == ST_WB) ? q.vb[q.vptr].blk : q.pend_addr;
    assign mem_req_wdata  = q.vb[q.vptr].data;
endmodule

// File: rtl/vcache_top_chk.sv
module vcache_top_chk
    import vcache_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cpu_req_valid,
    input logic                  cpu_req_ready,
    input logic                  cpu_resp_valid,
    input logic                  mem_req_valid,
    input logic                  mem_req_write,
    input logic [ADDR_W-1:0]     mem_req_addr,
    input logic [DATA_W-1:0]     mem_req_wdata,
    input logic                  mem_resp_valid,
    input logic                  dm_hit,
    input logic [VB_ENTRIES-1:0] vb_hit_vec
);
    // R11
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !cpu_req_ready);

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_resp_valid) |=>
        (mem_req_valid && $stable(mem_req_write) && $stable(mem_req_addr) && $stable(mem_req_wdata)));

    // R2
    dm_hit_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready && dm_hit) |=> cpu_resp_valid);

    // R7
    vb_hit_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready && (|vb_hit_vec)) |=> (!cpu_resp_valid ##1 cpu_resp_valid));

    // R4
    fill_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_write && mem_resp_valid) |=> cpu_resp_valid);

    // R10
    vb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vb_hit_vec));

    // R10
    one_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dm_hit && (|vb_hit_vec)));
endmodule

bind vcache_top vcache_top_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_req_valid  (cpu_req_valid),
    .cpu_req_ready  (cpu_req_ready),
    .cpu_resp_valid (cpu_resp_valid),
    .mem_req_valid  (mem_req_valid),
    .mem_req_write  (mem_req_write),
    .mem_req_addr   (mem_req_addr),
    .mem_req_wdata  (mem_req_wdata),
    .mem_resp_valid (mem_resp_valid),
    .dm_hit         (dm_hit),
    .vb_hit_vec     (vb_hit_vec)
);

// File: tb/vcache_top_tb_top.sv
`timescale 1ns/1ps
module vcache_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_ready;
    logic        cpu_req_write = 1'b0;
    logic [11:0] cpu_req_addr = '0;
    logic [31:0] cpu_req_wdata = '0;
    logic        cpu_resp_valid;
    logic [31:0] cpu_resp_rdata;
    logic        mem_req_valid;
    logic        mem_req_write;
    logic [11:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_resp_valid = 1'b0;
    logic [31:0] mem_resp_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vcache_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
        .cpu_req_wdata(cpu_req_wdata), .cpu_resp_valid(cpu_resp_valid),
        .cpu_resp_rdata(cpu_resp_rdata), .mem_req_valid(mem_req_valid),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_resp_valid(mem_resp_valid),
        .mem_resp_rdata(mem_resp_rdata)
    );

    task automatic check(input bit ok, input string rq, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] init_word(input logic [11:0] a);
        return {8'hC0, a, ~a};
    endfunction

    // Memory model: two-cycle latency, records traffic.
    logic [31:0] mem_store [int];
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [11:0] last_rd_addr = '0;
    logic [11:0] last_wr_addr = '0;
    logic [31:0] last_wr_data = '0;
    int          wait_cnt = 0;
    logic [11:0] start_addr = '0;

    always @(negedge clk) begin
        mem_resp_valid <= 1'b0;
        if (rst_n && mem_req_valid) begin
            if (wait_cnt == 0) start_addr = mem_req_addr;
            if (wait_cnt == 1) begin
                check(mem_req_addr == start_addr, "R12 request address held", mem_req_addr, start_addr);
                if (mem_req_write) begin
                    mem_store[int'(mem_req_addr)] = mem_req_wdata;
                    wr_cnt++;
                    last_wr_addr = mem_req_addr;
                    last_wr_data = mem_req_wdata;
                end else begin
                    rd_cnt++;
                    last_rd_addr = mem_req_addr;
                    mem_resp_rdata <= mem_store.exists(int'(mem_req_addr)) ?
                                      mem_store[int'(mem_req_addr)] : init_word(mem_req_addr);
                end
                mem_resp_valid <= 1'b1;
                wait_cnt = 0;
            end else begin
                wait_cnt++;
            end
        end
    end

    // Scoreboard
    logic [31:0] exp_q [$];
    string       rq_q [$];
    logic [31:0] shadow [int];

    always @(negedge clk) begin
        if (rst_n && cpu_resp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected response", cpu_resp_rdata, 0);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string r = rq_q.pop_front();
                check(cpu_resp_rdata == e, r, cpu_resp_rdata, e);
            end
        end
    end

    task automatic access(input bit wr, input int tg, input int ix, input logic [31:0] wd,
                          input int exp_lat, input int exp_rd, input int exp_wr, input string rq);
        logic [11:0] a;
        logic [31:0] e;
        int rd0, wr0, lat;
        a = 12'(tg * 16 + ix);
        if (wr) begin
            e = wd;
            shadow[int'(a)] = wd;
        end else begin
            e = shadow.exists(int'(a)) ? shadow[int'(a)] : init_word(a);
        end
        exp_q.push_back(e);
        rq_q.push_back({rq, " data"});
        rd0 = rd_cnt;
        wr0 = wr_cnt;
        @(negedge clk);
        while (!cpu_req_ready) @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_write = wr;
        cpu_req_addr  = a;
        cpu_req_wdata = wd;
        @(posedge clk);
        lat = 0;
        do begin
            @(negedge clk);
            if (lat == 0) begin
                cpu_req_valid = 1'b0;
                if (exp_lat > 1)
                    check(cpu_req_ready == 1'b0, "R11 ready low while busy", cpu_req_ready, 0);
            end
            lat++;
        end while (!cpu_resp_valid && lat < 40);
        check(lat == exp_lat, {rq, " latency"}, lat, exp_lat);
        check(rd_cnt - rd0 == exp_rd, {rq, " memory reads"}, rd_cnt - rd0, exp_rd);
        check(wr_cnt - wr0 == exp_wr, {rq, " memory writes"}, wr_cnt - wr0, exp_wr);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cpu_req_ready == 1'b1, "R1 ready after reset", cpu_req_ready, 1);
        check(cpu_resp_valid == 1'b0, "R1 no response in reset", cpu_resp_valid, 0);
        check(mem_req_valid == 1'b0, "R1 no memory request in reset", mem_req_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cpu_req_ready == 1'b1 && mem_req_valid == 1'b0, "R1 idle after reset", mem_req_valid, 0);

        access(0, 1, 0, 0, 3, 1, 0, "R1 R4 cold read miss");
        check(last_rd_addr == 12'd16, "R4 fetch address", last_rd_addr, 16);
        access(0, 1, 0, 0, 1, 0, 0, "R2 read hit");
        access(1, 1, 0, 32'h1111_AAAA, 1, 0, 0, "R2 write hit");
        access(0, 2, 0, 0, 3, 1, 0, "R6 conflict miss");
        access(0, 1, 0, 0, 2, 0, 0, "R6 R7 victim hit returns dirty line");
        access(0, 1, 0, 0, 1, 0, 0, "R7 R10 swapped line now array hit");
        access(0, 2, 0, 0, 2, 0, 0, "R7 displaced line in victim buffer");
        access(1, 3, 1, 32'h2222_BBBB, 1, 0, 0, "R5 write miss without fetch");
        access(0, 4, 0, 0, 3, 1, 0, "R6 fill victim slot");
        access(0, 5, 0, 0, 3, 1, 0, "R6 fill victim slot");
        access(0, 6, 0, 0, 3, 1, 0, "R6 fill victim slot");
        access(0, 7, 0, 0, 5, 1, 1, "R9 dirty oldest entry written back");
        check(last_wr_addr == 12'd16, "R9 write-back address", last_wr_addr, 16);
        check(last_wr_data == 32'h1111_AAAA, "R9 write-back data", last_wr_data, 32'h1111_AAAA);
        access(0, 8, 0, 0, 3, 1, 0, "R8 clean oldest entry dropped");
        access(0, 2, 0, 0, 3, 1, 0, "R8 dropped line refetched");
        access(0, 1, 0, 0, 3, 1, 0, "R9 R10 written-back data returns");
        access(0, 6, 0, 0, 2, 0, 0, "R8 later entry survives rotation");
        access(0, 3, 1, 0, 1, 0, 0, "R3 other index untouched");
        access(0, 1, 5, 0, 3, 1, 0, "R3 R4 index five miss");
        check(last_rd_addr == 12'd21, "R3 R4 fetch address", last_rd_addr, 21);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R10 all responses seen", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule